// File: doc/BRIEF.md
# Ethernet PHY LED controller

This block drives the three status LEDs of a multi-speed copper Ethernet PHY. Two programmable blink generators run from a slow tick input, at roughly 1 kHz. Each generator has its own rate code and on/off ratio code. Each LED has two registers:

- a 16-bit rule mask, which combines link speed, duplex and TX/RX/collision activity;
- a three-bit force field, which can override the rules with off, on or either generator.

One polarity bit, shared by all three pins, selects active-high or active-low drive.

Configuration goes through a small parallel register port. A read returns the selected register in the same cycle. Link status and activity strobes come straight from the PHY core. Each LED pin is registered, so it changes one clock after the conditions that decide it.

Top module: `phy_led_ctrl`

## Requirements
- R1: Reset is synchronous and active low. After reset:
  - address 0 reads 0x0000;
  - addresses 1 to 6 read 0x0000;
  - address 7 reads 0x0040;
  - all three LED pins are 0.
- R2: Register map and readback masks:
  - address 0 is the blink register, and only bits 11:0 are stored;
  - addresses 1, 2 and 3 are the full 16-bit rule masks of LED 0, 1 and 2;
  - addresses 4, 5 and 6 are the force fields of LED 0, 1 and 2, with only bits 15:13 stored;
  - address 7 is the polarity register, with only bit 6 stored.
  - A read returns the stored bits, and all other bits read 0.
- R3: Writes to addresses 8 to 15 change no register and no LED pin.
- R4: Each blink generator counts ticks in a period of 512 >> F ticks, where F is its 3-bit rate code. Code 0 gives the slowest rate, and each higher code halves the period. Generator 1 uses blink register bits 11:6, and generator 2 uses bits 5:0. In each field, F is bits 5:3.
- R5: A generator is high for floor(P*N/D) ticks at the start of each period P. N/D is chosen by the ratio code in field bits 2:0: 0=1/2, 1=3/4, 2=1/4, 3=1/3, 4=2/3, 5=1/6, 6=5/6, 7=1/12.
- R6: A new rate or ratio code takes effect only when the period that is running ends.
- R7: The force field has an enable bit and a mode field.
  - While bit 15 is set, bits 14:13 select the LED state: 0=off, 1=on, 2=generator 2 waveform, 3=generator 1 waveform.
  - The rule mask has no effect while force is enabled.
- R8: A steady-on condition holds when the link is up and either of these is true:
  - The speed matches an enabled speed bit. Speed input 0..3 means 10, 100, 1000 and 2500, and the bits are 4, 5, 6 and 15.
  - The duplex matches an enabled duplex bit: bit 12 for full, bit 11 for half.
- R9: Activity blink gates generator 1 onto the LED, XOR-ed with the steady-on state.
  - Activity is one of: an open TX window with bit 10, an open RX window with bit 9, or an open collision window with bit 3.
  - Qualification is one of: the bypass bit 13, the steady-on condition, or link up at a speed whose blink bit is set. The blink bits are 0, 1, 2 and 14 for 10, 100, 1000 and 2500.
  - The LED is driven this way only while activity and qualification are both present.
- R10: Each activity strobe opens a window for STRETCH_TICKS ticks, 10 by default. Ticks that arrive while a strobe is high do not count down. While the TX window is open and bit 8 is set, the LED is lit. The same holds for the RX window and bit 7. Without ticks the window stays open.
- R11: With an all-zero rule mask and force disabled, the LED stays unlit under any status or activity.
- R12: Each pin equals the lit state XOR the inverse of polarity bit 6. Pins are registered: a change in polarity or status reaches the pin one clock edge after the register or input changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | Timebase strobe (nominally 1 kHz, one clock wide) |
| link_i | input | 1 | Link up |
| speed_i | input | 2 | Link speed: 0=10, 1=100, 2=1000, 3=2500 |
| full_dup_i | input | 1 | 1 = full duplex, 0 = half duplex |
| tx_evt_i | input | 1 | TX activity strobe |
| rx_evt_i | input | 1 | RX activity strobe |
| col_evt_i | input | 1 | Collision strobe |
| wr_en_i | input | 1 | Register write enable |
| addr_i | input | 4 | Register address for read and write |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for addr_i (combinational) |
| led_o | output | 3 | LED pins, LED 0 in bit 0 |

## Verification
The results fall due at three different times:
- **Register reads** are combinational, so the bench samples them a moment after it drives the address.
- **Status, force and polarity changes** reach the pins one clock edge later. The bench samples at falling edges, at least one full edge after the change, and checks the polarity latency at exactly that one edge.
- **Generator waveforms and stretch windows** depend on tick phase. After a code change, the bench first waits out the longest old period. It then counts the lit cycles over a window that is a whole number of periods, or over a window longer than the stretch. With the tick held high every clock, the count equals the expected number of high ticks whatever the phase.

// File: rtl/phy_led_ctrl_pkg.sv
// Shared types and arithmetic for the PHY LED controller.
// Assumes the base period is a power of two no smaller than 128 ticks.
package phy_led_ctrl_pkg;

    typedef enum logic [1:0] {
        FRC_OFF  = 2'd0,
        FRC_ON   = 2'd1,
        FRC_GEN2 = 2'd2,
        FRC_GEN1 = 2'd3
    } frc_mode_e;

    typedef enum logic [1:0] {
        SPD_10   = 2'd0,
        SPD_100  = 2'd1,
        SPD_1000 = 2'd2,
        SPD_2500 = 2'd3
    } speed_e;

    typedef struct packed {
        logic      en;
        frc_mode_e mode;
    } frc_t;

    // rule mask bit positions
    localparam int PB_ON2500   = 15;
    localparam int PB_BLK2500  = 14;
    localparam int PB_BYPASS   = 13;
    localparam int PB_ON_FULL  = 12;
    localparam int PB_ON_HALF  = 11;
    localparam int PB_TX_BLK   = 10;
    localparam int PB_RX_BLK   = 9;
    localparam int PB_TX_HOLD  = 8;
    localparam int PB_RX_HOLD  = 7;
    localparam int PB_ON1000   = 6;
    localparam int PB_ON100    = 5;
    localparam int PB_ON10     = 4;
    localparam int PB_COL_BLK  = 3;
    localparam int PB_BLK1000  = 2;
    localparam int PB_BLK100   = 1;
    localparam int PB_BLK10    = 0;

    // period in ticks for a rate code
    function automatic int blink_period(input int base, input logic [2:0] rate);
        return base >> rate;
    endfunction

    // high ticks per period for a ratio code
    function automatic int blink_high(input int per, input logic [2:0] ratio);
        case (ratio)
            3'd0:    return per / 2;
            3'd1:    return (per * 3) / 4;
            3'd2:    return per / 4;
            3'd3:    return per / 3;
            3'd4:    return (per * 2) / 3;
            3'd5:    return per / 6;
            3'd6:    return (per * 5) / 6;
            default: return per / 12;
        endcase
    endfunction

endpackage

// File: rtl/phy_led_blink_gen.sv
// One blink generator: a tick-driven period counter whose output is high
// for the first part of each period. The codes are latched at period
// boundaries only. Assumes tick_i is a single-clock strobe.
module phy_led_blink_gen
    import phy_led_ctrl_pkg::*;
#(
    parameter int BASE_TICKS = 512
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_i,
    input  logic [5:0] cfg_i,
    output logic       wave_o
);
    localparam int CNT_W = $clog2(BASE_TICKS + 1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] per_w;
    logic [CNT_W-1:0] thr_w;
    logic [5:0]       cfg_q;
    logic             at_end;

    assign per_w  = CNT_W'(blink_period(BASE_TICKS, cfg_q[5:3]));
    assign thr_w  = CNT_W'(blink_high(int'(per_w), cfg_q[2:0]));
    assign at_end = (cnt_q >= per_w - CNT_W'(1));
    assign wave_o = (cnt_q < thr_w);

    // advance the period counter on each tick; take new codes at wrap
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            cfg_q <= '0;
        end else if (tick_i) begin
            if (at_end) begin
                cnt_q <= '0;
                cfg_q <= cfg_i;
            end else begin
                cnt_q <= cnt_q + CNT_W'(1);
            end
        end
    end

    AST_CNT_IN_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < per_w); // R4

    AST_CODE_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        !(tick_i && at_end) |=> $stable(cfg_q)); // R6

endmodule

// File: rtl/phy_led_stretch.sv
// Activity window: a strobe opens a window lasting a fixed number of
// ticks. A repeated strobe restarts it. The window is held while no tick
// arrives.
module phy_led_stretch #(
    parameter int STRETCH_TICKS = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic evt_i,
    output logic win_o
);
    localparam int SW = $clog2(STRETCH_TICKS + 1);

    logic [SW-1:0] cnt_q;

    assign win_o = (cnt_q != '0);

    // load on strobe, count down on tick
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (evt_i) begin
            cnt_q <= SW'(STRETCH_TICKS);
        end else if (tick_i && win_o) begin
            cnt_q <= cnt_q - SW'(1);
        end
    end

    AST_WIN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= SW'(STRETCH_TICKS)); // R10

    AST_EVT_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
        evt_i |=> win_o); // R10

endmodule

// File: rtl/phy_led_lane.sv
// Per-LED decision logic (combinational). It evaluates the rule mask
// against link status and activity windows, then applies the force
// override. Polarity and registering are done by the parent.
module phy_led_lane
    import phy_led_ctrl_pkg::*;
(
    input  logic [15:0] pat_i,
    input  frc_t        frc_i,
    input  logic        link_i,
    input  speed_e      speed_i,
    input  logic        full_dup_i,
    input  logic        tx_win_i,
    input  logic        rx_win_i,
    input  logic        col_win_i,
    input  logic        wave1_i,
    input  logic        wave2_i,
    output logic        lit_o
);
    logic spd_on;
    logic spd_blk;
    logic on_cond;
    logic qual;
    logic act;
    logic hold;
    logic rule_lit;

    // select the speed-specific steady and blink bits
    always_comb begin
        case (speed_i)
            SPD_10:   begin spd_on = pat_i[PB_ON10];   spd_blk = pat_i[PB_BLK10];   end
            SPD_100:  begin spd_on = pat_i[PB_ON100];  spd_blk = pat_i[PB_BLK100];  end
            SPD_1000: begin spd_on = pat_i[PB_ON1000]; spd_blk = pat_i[PB_BLK1000]; end
            default:  begin spd_on = pat_i[PB_ON2500]; spd_blk = pat_i[PB_BLK2500]; end
        endcase
    end

    // combine steady, activity and hold rules
    always_comb begin
        on_cond  = link_i & (spd_on | (full_dup_i ? pat_i[PB_ON_FULL] : pat_i[PB_ON_HALF]));
        qual     = pat_i[PB_BYPASS] | on_cond | (link_i & spd_blk);
        act      = (pat_i[PB_TX_BLK] & tx_win_i) | (pat_i[PB_RX_BLK] & rx_win_i)
                 | (pat_i[PB_COL_BLK] & col_win_i);
        hold     = (pat_i[PB_TX_HOLD] & tx_win_i) | (pat_i[PB_RX_HOLD] & rx_win_i);
        rule_lit = hold | (on_cond ^ (qual & act & wave1_i));
    end

    // force override selects the final lit state
    always_comb begin
        if (frc_i.en) begin
            case (frc_i.mode)
                FRC_OFF:  lit_o = 1'b0;
                FRC_ON:   lit_o = 1'b1;
                FRC_GEN2: lit_o = wave2_i;
                default:  lit_o = wave1_i;
            endcase
        end else begin
            lit_o = rule_lit;
        end
    end

endmodule

// File: rtl/phy_led_ctrl.sv
// Top of the PHY LED controller. It holds:
//   - the register file (blink, rule masks, force fields, polarity);
//   - two blink generators and three activity stretchers;
//   - one decision lane per LED;
//   - the registered, polarity-applied pins.
// Assumes a single-clock domain. The PHY core supplies tick_i and the
// strobes already synchronised.
module phy_led_ctrl
    import phy_led_ctrl_pkg::*;
#(
    parameter int NUM_LEDS      = 3,
    parameter int ADDR_W        = 4,
    parameter int BASE_TICKS    = 512,
    parameter int STRETCH_TICKS = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              link_i,
    input  logic [1:0]        speed_i,
    input  logic              full_dup_i,
    input  logic              tx_evt_i,
    input  logic              rx_evt_i,
    input  logic              col_evt_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [15:0]       wdata_i,
    output logic [15:0]       rdata_o,
    output logic [NUM_LEDS-1:0] led_o
);
    localparam int PAT_BASE = 1;
    localparam int FRC_BASE = PAT_BASE + NUM_LEDS;
    localparam int POL_ADDR = FRC_BASE + NUM_LEDS;
    localparam int NUM_GEN  = 2;
    localparam int NUM_SRC  = 3;

    logic [11:0]                blink_q;
    logic [NUM_LEDS-1:0][15:0]  pat_q;
    frc_t [NUM_LEDS-1:0]        frc_q;
    logic                       pol_q;
    logic [NUM_GEN-1:0]         wave;
    logic [NUM_SRC-1:0]         evt;
    logic [NUM_SRC-1:0]         win;
    logic [NUM_LEDS-1:0]        lit;

    // register writes; unmapped addresses fall through
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            blink_q <= '0;
            pat_q   <= '0;
            frc_q   <= '0;
            pol_q   <= 1'b1;
        end else if (wr_en_i) begin
            if (int'(addr_i) == 0) blink_q <= wdata_i[11:0];
            for (int i = 0; i < NUM_LEDS; i++) begin
                if (int'(addr_i) == PAT_BASE + i) pat_q[i] <= wdata_i;
                if (int'(addr_i) == FRC_BASE + i) frc_q[i] <= frc_t'(wdata_i[15:13]);
            end
            if (int'(addr_i) == POL_ADDR) pol_q <= wdata_i[6];
        end
    end

    // combinational read mux
    always_comb begin
        rdata_o = '0;
        if (int'(addr_i) == 0) rdata_o = {4'b0, blink_q};
        for (int i = 0; i < NUM_LEDS; i++) begin
            if (int'(addr_i) == PAT_BASE + i) rdata_o = pat_q[i];
            if (int'(addr_i) == FRC_BASE + i) rdata_o = {frc_q[i], 13'b0};
        end
        if (int'(addr_i) == POL_ADDR) rdata_o = {9'b0, pol_q, 6'b0};
    end

    // generator 0 takes bits 11:6 (generator 1), generator 1 takes bits 5:0 (generator 2)
    for (genvar g = 0; g < NUM_GEN; g++) begin : g_gen
        phy_led_blink_gen #(.BASE_TICKS(BASE_TICKS)) u_gen (
            .clk    (clk),
            .rst_n  (rst_n),
            .tick_i (tick_i),
            .cfg_i  (blink_q[11-6*g -: 6]),
            .wave_o (wave[g])
        );
    end

    assign evt = {col_evt_i, rx_evt_i, tx_evt_i};

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
        phy_led_stretch #(.STRETCH_TICKS(STRETCH_TICKS)) u_str (
            .clk    (clk),
            .rst_n  (rst_n),
            .tick_i (tick_i),
            .evt_i  (evt[s]),
            .win_o  (win[s])
        );
    end

    for (genvar i = 0; i < NUM_LEDS; i++) begin : g_led
        phy_led_lane u_lane (
            .pat_i      (pat_q[i]),
            .frc_i      (frc_q[i]),
            .link_i     (link_i),
            .speed_i    (speed_e'(speed_i)),
            .full_dup_i (full_dup_i),
            .tx_win_i   (win[0]),
            .rx_win_i   (win[1]),
            .col_win_i  (win[2]),
            .wave1_i    (wave[0]),
            .wave2_i    (wave[1]),
            .lit_o      (lit[i])
        );

        AST_FORCE_OFF_DARK: assert property (@(posedge clk) disable iff (!rst_n)
            (frc_q[i].en && frc_q[i].mode == FRC_OFF) |=> (led_o[i] == ~$past(pol_q))); // R7

        AST_FORCE_ON_LIT: assert property (@(posedge clk) disable iff (!rst_n)
            (frc_q[i].en && frc_q[i].mode == FRC_ON) |=> (led_o[i] == $past(pol_q))); // R7
    end

    // registered pins with global polarity
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            led_o <= '0;
        end else begin
            led_o <= lit ^ {NUM_LEDS{~pol_q}};
        end
    end

    AST_UNDEF_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && int'(addr_i) > POL_ADDR) |=>
        ($stable(blink_q) && $stable(pat_q) && $stable(frc_q) && $stable(pol_q))); // R3

endmodule

// File: tb/phy_led_ctrl_bench.sv
// Self-checking bench for phy_led_ctrl: register, rule, force and
// generator sweeps with arithmetically derived expectations.
module phy_led_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_i = 1'b1;
    logic        link_i = 1'b0;
    logic [1:0]  speed_i = 2'd0;
    logic        full_dup_i = 1'b0;
    logic        tx_evt_i = 1'b0;
    logic        rx_evt_i = 1'b0;
    logic        col_evt_i = 1'b0;
    logic        wr_en_i = 1'b0;
    logic [3:0]  addr_i = 4'd0;
    logic [15:0] wdata_i = 16'd0;
    logic [15:0] rdata_o;
    logic [2:0]  led_o;

    int n_chk = 0;
    int n_bad = 0;
    int max_p = 512;

    always #4 clk = ~clk;

    phy_led_ctrl u_phy_led_ctrl (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .link_i(link_i),
        .speed_i(speed_i), .full_dup_i(full_dup_i), .tx_evt_i(tx_evt_i),
        .rx_evt_i(rx_evt_i), .col_evt_i(col_evt_i), .wr_en_i(wr_en_i),
        .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .led_o(led_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en_i = 1'b1; addr_i = a; wdata_i = d;
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [3:0] a, input int exp);
        addr_i = a;
        #1;
        chk(req, int'(rdata_o), exp);
    endtask

    task automatic count_ones(input int idx, input int n, output int ones);
        ones = 0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            ones += int'(led_o[idx]);
        end
    endtask

    function automatic int exp_high(input int p, input int d);
        case (d)
            0: return p / 2;
            1: return (p * 3) / 4;
            2: return p / 4;
            3: return p / 3;
            4: return (p * 2) / 3;
            5: return p / 6;
            6: return (p * 5) / 6;
            default: return p / 12;
        endcase
    endfunction

    function automatic int exp_steady(input logic [15:0] pat, input logic lk,
                                      input logic [1:0] spd, input logic fd);
        logic s;
        case (spd)
            2'd0: s = pat[4];
            2'd1: s = pat[5];
            2'd2: s = pat[6];
            default: s = pat[15];
        endcase
        return int'(lk & (s | (fd ? pat[12] : pat[11])));
    endfunction

    task automatic set_gen(input int f1, input int d1, input int f2, input int d2);
        int np;
        wr(4'd0, 16'(((f1 * 8 + d1) << 6) | (f2 * 8 + d2)));
        repeat (max_p + 3) @(negedge clk);
        np = ((512 >> f1) > (512 >> f2)) ? (512 >> f1) : (512 >> f2);
        max_p = np;
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        int ones;
        logic [15:0] pv [3];

        repeat (5) @(negedge clk);
        // R1 reset state
        chk("R1 pins", int'(led_o), 0);
        rd_chk("R1 blink", 4'd0, 0);
        for (int a = 1; a <= 6; a++) rd_chk("R1 rule/force", 4'(a), 0);
        rd_chk("R1 polarity", 4'd7, 16'h0040);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 readback masks
        wr(4'd0, 16'hFFFF);  rd_chk("R2 blink mask", 4'd0, 16'h0FFF);
        wr(4'd1, 16'hA5C3);  rd_chk("R2 rule0", 4'd1, 16'hA5C3);
        wr(4'd2, 16'h5A3C);  rd_chk("R2 rule1", 4'd2, 16'h5A3C);
        wr(4'd3, 16'hFFFF);  rd_chk("R2 rule2", 4'd3, 16'hFFFF);
        wr(4'd5, 16'hFFFF);  rd_chk("R2 force mask", 4'd5, 16'hE000);
        wr(4'd7, 16'hFFBF);  rd_chk("R2 pol clear", 4'd7, 16'h0000);
        wr(4'd7, 16'hFFFF);  rd_chk("R2 pol mask", 4'd7, 16'h0040);
        wr(4'd0, 16'h0000);
        for (int a = 1; a <= 6; a++) wr(4'(a), 16'h0000);

        // R3 undefined addresses ignored
        for (int a = 8; a < 16; a++) wr(4'(a), 16'hFFFF);
        repeat (2) @(negedge clk);
        for (int a = 0; a <= 6; a++) rd_chk("R3 regs", 4'(a), 0);
        rd_chk("R3 pol", 4'd7, 16'h0040);
        chk("R3 pins", int'(led_o), 0);

        // R11 zero mask stays dark under all activity
        link_i = 1'b1; speed_i = 2'd2; full_dup_i = 1'b1;
        tx_evt_i = 1'b1; rx_evt_i = 1'b1; col_evt_i = 1'b1;
        ones = 0;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            ones += int'(led_o[0]) + int'(led_o[1]) + int'(led_o[2]);
        end
        chk("R11 zero mask", ones, 0);
        tx_evt_i = 1'b0; rx_evt_i = 1'b0; col_evt_i = 1'b0;
        repeat (15) @(negedge clk);

        // R8 steady-on sweep over link, speed and duplex
        pv[0] = 16'h8010; pv[1] = 16'h1000; pv[2] = 16'h0820;
        for (int i = 0; i < 3; i++) wr(4'(1 + i), pv[i]);
        for (int lk = 0; lk < 2; lk++)
            for (int sp = 0; sp < 4; sp++)
                for (int fd = 0; fd < 2; fd++) begin
                    link_i = 1'(lk); speed_i = 2'(sp); full_dup_i = 1'(fd);
                    repeat (2) @(negedge clk);
                    for (int i = 0; i < 3; i++)
                        chk($sformatf("R8 led%0d lk%0d sp%0d fd%0d", i, lk, sp, fd),
                            int'(led_o[i]), exp_steady(pv[i], 1'(lk), 2'(sp), 1'(fd)));
                end

        // R7 force override (LED1 rule is full-duplex on)
        link_i = 1'b1; full_dup_i = 1'b1;
        set_gen(7, 1, 6, 2);
        wr(4'd5, 16'h8000); repeat (2) @(negedge clk);
        chk("R7 forced off", int'(led_o[1]), 0);
        wr(4'd2, 16'h0000); wr(4'd5, 16'hA000); repeat (2) @(negedge clk);
        chk("R7 forced on", int'(led_o[1]), 1);
        wr(4'd5, 16'hE000); count_ones(1, 8, ones);
        chk("R7 follow gen1", ones, 6);
        wr(4'd5, 16'hC000); count_ones(1, 8, ones);
        chk("R7 follow gen2", ones, 2);
        wr(4'd5, 16'h6000); wr(4'd2, 16'h1000); repeat (2) @(negedge clk);
        chk("R7 disabled follows rules", int'(led_o[1]), 1);
        wr(4'd2, 16'h0000);
        for (int i = 0; i < 3; i++) wr(4'(1 + i), 16'h0000);

        // R4 R5 generator 1 full sweep via LED0, generator 2 rate sweep via LED2
        wr(4'd4, 16'hE000);
        wr(4'd6, 16'hC000);
        for (int d = 0; d < 8; d++)
            for (int f = 0; f < 8; f++) begin
                set_gen(f, d, 7, 0);
                count_ones(0, 512 >> f, ones);
                chk($sformatf("R4 R5 gen1 f%0d d%0d", f, d), ones, exp_high(512 >> f, d));
            end
        for (int f = 0; f < 8; f++) begin
            set_gen(7, 0, f, 3);
            count_ones(2, 2 * (512 >> f), ones);
            chk($sformatf("R4 gen2 f%0d", f), ones, 2 * exp_high(512 >> f, 3));
        end

        // R6 code change waits for the period boundary
        set_gen(0, 0, 7, 0);
        while (led_o[0] == 1'b1) @(negedge clk);
        while (led_o[0] == 1'b0) @(negedge clk);
        wr(4'd0, 16'(((7 * 8 + 0) << 6) | 56));
        count_ones(0, 200, ones);
        chk("R6 old period kept", ones, 200);
        repeat (400) @(negedge clk);
        count_ones(0, 8, ones);
        chk("R6 new code applied", ones, 4);
        max_p = 4;
        wr(4'd4, 16'h0000); wr(4'd6, 16'h0000);

        // R9 activity blink, gen1 = P4 high 3
        set_gen(7, 1, 7, 0);
        link_i = 1'b0;
        tx_evt_i = 1'b1;
        wr(4'd1, 16'h2400); repeat (3) @(negedge clk); count_ones(0, 8, ones);
        chk("R9 bypass tx blink", ones, 6);
        wr(4'd1, 16'h0400); repeat (3) @(negedge clk); count_ones(0, 8, ones);
        chk("R9 unqualified tx", ones, 0);
        link_i = 1'b1; speed_i = 2'd2;
        wr(4'd1, 16'h0404); repeat (3) @(negedge clk); count_ones(0, 8, ones);
        chk("R9 speed-qualified blink", ones, 6);
        wr(4'd1, 16'h0440); repeat (3) @(negedge clk); count_ones(0, 8, ones);
        chk("R9 inverted over steady", ones, 2);
        tx_evt_i = 1'b0; rx_evt_i = 1'b1;
        wr(4'd1, 16'h2200); repeat (3) @(negedge clk); count_ones(0, 8, ones);
        chk("R9 rx blink", ones, 6);
        rx_evt_i = 1'b0; col_evt_i = 1'b1;
        wr(4'd1, 16'h2008); repeat (3) @(negedge clk); count_ones(0, 8, ones);
        chk("R9 collision blink", ones, 6);
        col_evt_i = 1'b0;
        repeat (15) @(negedge clk);

        // R10 hold windows
        link_i = 1'b0;
        wr(4'd1, 16'h0100);
        @(negedge clk); tx_evt_i = 1'b1; @(negedge clk); tx_evt_i = 1'b0;
        count_ones(0, 30, ones);
        chk("R10 tx hold length", ones, 10);
        wr(4'd1, 16'h0080);
        @(negedge clk); rx_evt_i = 1'b1; @(negedge clk); rx_evt_i = 1'b0;
        count_ones(0, 30, ones);
        chk("R10 rx hold length", ones, 10);
        wr(4'd1, 16'h0100);
        @(negedge clk); tx_evt_i = 1'b1; @(negedge clk); tx_evt_i = 1'b0; tick_i = 1'b0;
        repeat (40) @(negedge clk);
        chk("R10 held without ticks", int'(led_o[0]), 1);
        tick_i = 1'b1;
        count_ones(0, 30, ones);
        chk("R10 countdown after ticks", ones, 10);

        // R12 polarity: LED0 steady on, LED1 dark
        link_i = 1'b1; speed_i = 2'd2;
        wr(4'd1, 16'h0040); wr(4'd2, 16'h0000);
        repeat (2) @(negedge clk);
        chk("R12 active high", int'(led_o[1:0]), 1);
        wr(4'd7, 16'h0000);
        chk("R12 one-edge latency", int'(led_o[1:0]), 1);
        @(negedge clk);
        chk("R12 active low", int'(led_o[1:0]), 2);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule